// File: doc/BRIEF.md
# Displacement-Addressed Load/Store Unit

This block is the memory-access stage of an accumulator machine that reaches data memory only through a dedicated address register. One operation copies the accumulator into that register. Word and byte loads and stores then compute their effective address from the register plus a signed 8-bit displacement. Word operations multiply the displacement by four. Byte operations add it as it is.

The unit drives a single-cycle synchronous data memory with an address, write data, a byte-enable mask, a write strobe and a read strobe. Read data comes back one cycle after the request. The unit then returns either the whole word or the addressed byte, sign-extended, together with a valid strobe that tells the accumulator when to take it. Byte lanes are little-endian: address bits 1:0 equal to 0 select bits 7:0 of the data word.

Top module: `addr_reg_lsu`

## Requirements
- R1: While reset is held and after its release, the address register reads zero and `memWe`, `memRe` and `ldValid` are low until an operation is issued.
- R2: An operation with `opCode` 1 (set address) and `opValid` high loads `accIn` into the address register at the clock edge. No other operation changes the register.
- R3: For word operations (`opCode` 2 load, 4 store), `memAddr` equals the address register plus the sign-extended displacement times four, in the same cycle as the request.
- R4: For byte operations (`opCode` 3 load, 5 store), `memAddr` equals the address register plus the sign-extended, unscaled displacement, in the same cycle as the request.
- R5: A word store raises `memWe` in the request cycle with `memWdata` equal to `accIn` and all four bits of `memBe` set.
- R6: A byte store raises `memWe` with `accIn[7:0]` copied onto all four lanes of `memWdata` and exactly one `memBe` bit set, bit number `memAddr[1:0]`.
- R7: A word load raises `memRe` in the request cycle. In the following cycle `ldValid` is high and `ldData` equals the word returned on `memRdata`.
- R8: A byte load returns, one cycle later with `ldValid`, the byte of `memRdata` at bits `8*k+7:8*k`, where k is `memAddr[1:0]` of the request, sign-extended from its bit 7 to 32 bits.
- R9: With `opValid` low, or with `opCode` 0 or 1, neither memory strobe is raised, and `ldValid` is never high in a cycle that does not follow a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is issued this cycle |
| opCode | input | 3 | 0 none, 1 set address, 2 word load, 3 byte load, 4 word store, 5 byte store |
| disp | input | 8 | Signed displacement |
| accIn | input | 32 | Accumulator value |
| memAddr | output | 32 | Byte address to memory |
| memWdata | output | 32 | Write data to memory |
| memBe | output | 4 | Byte-enable mask, bit k covers bits 8k+7:8k |
| memWe | output | 1 | Write strobe |
| memRe | output | 1 | Read strobe |
| memRdata | input | 32 | Read data, one cycle after `memRe` |
| ldValid | output | 1 | Load result is valid this cycle |
| ldData | output | 32 | Load result for the accumulator |
| addrRegOut | output | 32 | Current address register |

## Verification
The unit is driven with word stores and loads at zero, positive and negative displacements, so that a missing scale or a missing sign extension produces a wrong address. Byte stores go to each of the four lanes of one word and are read back lane by lane. This separates correct lane selection and byte-enable generation from swapped or stuck lanes. Byte values with bit 7 set and clear show whether the result is sign-extended or zero-extended. Back-to-back loads, idle cycles and a second address-register load show that results stay paired with their requests, that idle cycles produce no strobes, and that only the set operation moves the register.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_SETAR = 3'd1,
    OP_LDW   = 3'd2,
    OP_LDB   = 3'd3,
    OP_STW   = 3'd4,
    OP_STB   = 3'd5
  } lsu_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic arLoad;    // copy accumulator into address register
    logic memRead;   // load request this cycle
    logic memWrite;  // store request this cycle
    logic byteOp;    // current request is a byte access
    logic retValid;  // load data returns this cycle
    logic retByte;   // returning load is a byte load
  } lsu_ctrl_t;

endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opCode,
  output lsu_ctrl_t  ctrl
);

  lsu_op_e op;
  logic    ldPend;
  logic    ldPendByte;
  logic    isRead;
  logic    isWrite;
  logic    isByte;

  assign op = lsu_op_e'(opCode);

  always_comb begin
    isRead  = 1'b0;
    isWrite = 1'b0;
    isByte  = 1'b0;
    if (opValid) begin
      unique case (op)
        OP_LDW:  isRead = 1'b1;
        OP_LDB:  begin isRead = 1'b1;  isByte = 1'b1; end
        OP_STW:  isWrite = 1'b1;
        OP_STB:  begin isWrite = 1'b1; isByte = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldPend     <= 1'b0;
      ldPendByte <= 1'b0;
    end else begin
      ldPend     <= isRead;
      ldPendByte <= isRead & isByte;
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.arLoad   = opValid && (op == OP_SETAR);
    ctrl.memRead  = isRead;
    ctrl.memWrite = isWrite;
    ctrl.byteOp   = isByte;
    ctrl.retValid = ldPend;
    ctrl.retByte  = ldPendByte;
  end

endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsu_ctrl_t         ctrl,
  input  logic [DISP_W-1:0] disp,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W/8-1:0] memBe,
  output logic [DATA_W-1:0] ldData,
  output logic [ADDR_W-1:0] addrReg
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] offset;
  logic [LANE_W-1:0] lane;
  logic [LANE_W-1:0] laneQ;
  logic [7:0]        rdBytes [LANES];
  logic [7:0]        pickByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (ctrl.arLoad) begin
      addrReg <= ADDR_W'(accIn);
    end
  end

  // Word accesses scale the displacement by the word size; byte accesses do not
  assign dispExt = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign offset  = ctrl.byteOp ? dispExt : (dispExt << LANE_W);
  assign memAddr = addrReg + offset;
  assign lane    = memAddr[LANE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneQ <= '0;
    end else if (ctrl.memRead) begin
      laneQ <= lane;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign memWdata[g*8 +: 8] = ctrl.byteOp ? accIn[7:0] : accIn[g*8 +: 8];
    assign memBe[g]           = ctrl.memWrite &&
                                (!ctrl.byteOp || (lane == LANE_W'(g)));
    assign rdBytes[g]         = memRdata[g*8 +: 8];
  end

  assign pickByte = rdBytes[laneQ];
  assign ldData   = ctrl.retByte ? {{(DATA_W-8){pickByte[7]}}, pickByte} : memRdata;

endmodule

// File: rtl/addr_reg_lsu.sv
module addr_reg_lsu
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [2:0]          opCode,
  input  logic [DISP_W-1:0]   disp,
  input  logic [DATA_W-1:0]   accIn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W/8-1:0] memBe,
  output logic                memWe,
  output logic                memRe,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                ldValid,
  output logic [DATA_W-1:0]   ldData,
  output logic [ADDR_W-1:0]   addrRegOut
);

  lsu_ctrl_t ctrl;

  lsu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .ctrl    (ctrl)
  );

  lsu_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .disp     (disp),
    .accIn    (accIn),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memBe    (memBe),
    .ldData   (ldData),
    .addrReg  (addrRegOut)
  );

  assign memWe   = ctrl.memWrite;
  assign memRe   = ctrl.memRead;
  assign ldValid = ctrl.retValid;

endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                opValid,
  input logic [2:0]          opCode,
  input logic [DATA_W/8-1:0] memBe,
  input logic                memWe,
  input logic                memRe,
  input logic                ldValid,
  input logic [DATA_W-1:0]   ldData,
  input logic [ADDR_W-1:0]   addrRegOut
);

  p_ar_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && opCode == 3'd1) |=> $stable(addrRegOut));

  p_word_be_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && opCode == 3'd4) |-> (memBe == '1));

  p_byte_be_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && opCode == 3'd5) |-> ($countones(memBe) == 1));

  p_load_return_r7: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> ldValid);

  p_byte_sign_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && $past(opCode == 3'd3)) |-> (ldData[DATA_W-1:8] == {(DATA_W-8){ldData[7]}}));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!memWe && !memRe));

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rstN)
    !memRe |=> !ldValid);

endmodule

bind addr_reg_lsu lsu_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .DISP_W (DISP_W)
) u_chk (.*);

// File: tb/tb_addr_reg_lsu.sv
module tb_addr_reg_lsu;

  localparam logic [2:0] NOP = 3'd0, SETAR = 3'd1, LDW = 3'd2, LDB = 3'd3, STW = 3'd4, STB = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = NOP;
  logic [7:0]  disp = '0;
  logic [31:0] accIn = '0;
  logic [31:0] memAddr, memWdata, memRdata, ldData, addrRegOut;
  logic [3:0]  memBe;
  logic        memWe, memRe, ldValid;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] mem    [64];
  logic [31:0] shadow [64];
  logic [31:0] arModel = '0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #5 clk = ~clk;

  addr_reg_lsu dut (.*);

  // Behavioural synchronous memory
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      memRdata <= '0;
    end else begin
      if (memWe)
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[7:2]][b*8 +: 8] <= memWdata[b*8 +: 8];
      if (memRe) memRdata <= mem[memAddr[7:2]];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: issues one operation, checks request-cycle outputs, queues load results
  task automatic doOp(input logic [2:0] op, input logic [7:0] d, input logic [31:0] acc);
    logic [31:0] dx, ea, ex;
    logic [1:0]  ln;
    @(negedge clk);
    opValid = 1'b1; opCode = op; disp = d; accIn = acc;
    #1;
    check(addrRegOut == arModel, "R2", addrRegOut, arModel);
    dx = {{24{d[7]}}, d};
    ea = (op == LDB || op == STB) ? arModel + dx : arModel + (dx << 2);
    ln = ea[1:0];
    case (op)
      SETAR: begin
        check(!memWe && !memRe, "R9", {memWe, memRe}, 0);
        arModel = acc;
      end
      STW: begin
        check(memAddr == ea, "R3", memAddr, ea);
        check(memWe && memBe == 4'hF && memWdata == acc, "R5", memWdata, acc);
        shadow[ea[7:2]] = acc;
      end
      STB: begin
        check(memAddr == ea, "R4", memAddr, ea);
        check(memWe && memBe == (4'b1 << ln) && memWdata == {4{acc[7:0]}}, "R6",
              {memBe, memWdata[27:0]}, {(4'b1 << ln), {4{acc[7:0]}}[27:0]});
        shadow[ea[7:2]][ln*8 +: 8] = acc[7:0];
      end
      LDW: begin
        check(memAddr == ea, "R3", memAddr, ea);
        check(memRe && !memWe, "R7", {memRe, memWe}, 2);
        expQ.push_back(shadow[ea[7:2]]); tagQ.push_back("R7");
      end
      LDB: begin
        check(memAddr == ea, "R4", memAddr, ea);
        ex = {{24{shadow[ea[7:2]][ln*8+7]}}, shadow[ea[7:2]][ln*8 +: 8]};
        expQ.push_back(ex); tagQ.push_back("R8");
      end
      default: check(!memWe && !memRe, "R9", {memWe, memRe}, 0);
    endcase
  endtask

  task automatic idle();
    @(negedge clk);
    opValid = 1'b0; opCode = LDW; disp = '0; accIn = '0;
    #1;
    check(!memWe && !memRe, "R9", {memWe, memRe}, 0);
  endtask

  // Monitor: pops expected load results as the design returns them
  always @(negedge clk) begin
    if (rstN && ldValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", ldData, 0);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(ldData == e, t, ldData, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check(addrRegOut == 0 && !memWe && !memRe && !ldValid, "R1", addrRegOut, 0);
    @(negedge clk); rstN = 1'b1;
    #1;
    check(addrRegOut == 0 && !memWe && !memRe && !ldValid, "R1", addrRegOut, 0);

    doOp(SETAR, 8'h00, 32'h0000_0040);
    doOp(STW, 8'h00, 32'hDEAD_BEEF);
    doOp(STW, 8'h01, 32'h0123_4567);
    doOp(STW, 8'hFF, 32'h80FF_7F10);   // negative displacement -> 0x3C
    doOp(LDW, 8'h00, 32'h0);
    doOp(LDW, 8'hFF, 32'h0);
    doOp(LDW, 8'h01, 32'h0);
    idle();
    doOp(STB, 8'h08, 32'h1111_1185);   // 0x48 lane 0
    doOp(STB, 8'h09, 32'h2222_2212);   // lane 1
    doOp(STB, 8'h0A, 32'h3333_337F);   // lane 2
    doOp(STB, 8'h0B, 32'h4444_44C3);   // lane 3
    doOp(LDB, 8'h08, 32'h0);
    doOp(LDB, 8'h09, 32'h0);
    doOp(LDB, 8'h0A, 32'h0);
    doOp(LDB, 8'h0B, 32'h0);
    doOp(LDB, 8'hFF, 32'h0);           // 0x3F lane 3 = 0x80
    doOp(LDB, 8'hFC, 32'h0);           // 0x3C lane 0 = 0x10
    doOp(LDB, 8'h02, 32'h0);           // 0x42 lane 2 of DEADBEEF
    doOp(NOP, 8'h05, 32'hFFFF_FFFF);
    idle();
    doOp(SETAR, 8'h00, 32'h0000_0080);
    doOp(LDW, 8'hF0, 32'h0);           // 0x80 - 64 = 0x40
    doOp(LDB, 8'hBC, 32'h0);           // 0x80 - 68 = 0x3C
    doOp(STB, 8'hC5, 32'h0000_00A7);   // 0x45 lane 1
    doOp(LDW, 8'hF1, 32'h0);           // 0x44
    idle();
    idle();
    idle();
    check(expQ.size() == 0, "R7", expQ.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule